// File: doc/BRIEF.md
# Two-Wire Bus Write Receiver with Split Acknowledge

This block is the slave side of a two-wire serial bus that only ever accepts writes. It samples the clock line and the data line with the system clock, finds the start and stop framing events, counts nine bus clocks per byte, and decides for each byte whether to pull the acknowledge line low. The acknowledge is driven on an output of its own that is separate from the data input. The two can be joined into one bus line or left apart when the acknowledge path cannot reach a clean low level.

The first byte after a start (or repeated start) is an address byte: seven address bits followed by a direction bit. When it matches the programmed address and asks for a write, every later byte is acknowledged and handed to the core on an 8-bit output with a one-cycle strobe, until a stop or a new start. A high-speed master code as the first byte is recognised and never acknowledged. A configuration input withholds every acknowledge while reception continues unchanged.

Top module: `twire_wr_slave`

## Requirements
- R1: After reset the acknowledge output is released (high), and `rx_valid_o` and `stop_o` are low. With no START on the bus nothing is accepted.
- R2: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP. Both clear the bit count. A repeated START in the middle of a byte discards the partial byte and begins a new address phase.
- R3: Data bits are taken on the SCL rising edge, most significant bit first, eight per byte. The ninth clock is the acknowledge slot.
- R4: Each byte received after a matching write address appears on `rx_data_o` with `rx_valid_o` high for exactly one system clock. That strobe comes in the same cycle as the acknowledge for the byte is asserted.
- R5: The acknowledge output goes low after the SCL falling edge that ends bit 8, stays low through the ninth clock, and is released after the SCL falling edge that ends the ninth clock.
- R6: While `ack_dis_i` is high no acknowledge is driven, and accepted data bytes are still delivered on `rx_data_o`/`rx_valid_o`.
- R7: Every STOP produces exactly one one-cycle pulse on `stop_o`.
- R8: An address byte whose bits [7:1] equal `own_addr_i` and whose bit 0 is 0 (write) is acknowledged.
- R9: An address byte that differs in bits [7:1], or has bit 0 = 1 (read), is not acknowledged. The block then ignores the bus (no acknowledge, no strobe) until the next START.
- R10: A first byte matching 00001xxx (the high-speed master code) is not acknowledged and not delivered. A repeated START followed by a matching address is then served normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line input (asynchronous) |
| own_addr_i | input | 7 | Programmed 7-bit slave address |
| ack_dis_i | input | 1 | 1 = never drive acknowledge |
| ack_n_o | output | 1 | Open-drain acknowledge: 0 = pull line low, 1 = release |
| rx_data_o | output | 8 | Last accepted data byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_data_o` |
| stop_o | output | 1 | One-cycle strobe on each STOP |

## Verification
Delivery of a data byte and assertion of its acknowledge fall on the same system clock: both are decided on the SCL falling edge that closes bit 8. Every data byte sent after a matching address provokes this. The bench's behavioural model queues the expected bytes and checks each strobe against the head of the queue on every clock. In the same ninth clock it checks that the acknowledge is low in the SCL high phase and released once SCL has fallen again. The same overlap is repeated with acknowledge disabled, where the strobe must still arrive while the acknowledge stays released.

// File: rtl/twire_pkg.sv
package twire_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_t;

  // High-speed master code: upper five bits 00001, low three free
  function automatic logic f_is_master_code(input logic [BYTE_W-1:0] b);
    return (b[BYTE_W-1:3] == 5'b00001);
  endfunction

  // Address byte hits when upper seven bits match and direction is write (0)
  function automatic logic f_addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [ADDR_W-1:0] a);
    return (b[BYTE_W-1:1] == a) && !b[0];
  endfunction

endpackage

// File: rtl/twire_sync.sv
module twire_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] pipe [STAGES];

  // Reset to all-high: an idle bus reads high on both lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '1;
    end else begin
      pipe[0] <= async_i;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign sync_o = pipe[STAGES-1];

endmodule

// File: rtl/twire_cond.sv
module twire_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  =  scl_s && !scl_q;
  assign scl_fall  = !scl_s &&  scl_q;
  // SCL high on both samples, SDA moving between them
  assign start_evt = scl_s && scl_q &&  sda_q && !sda_s;
  assign stop_evt  = scl_s && scl_q && !sda_q &&  sda_s;

endmodule

// File: rtl/twire_byte_rx.sv
module twire_byte_rx
  import twire_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              ack_dis_i,
  output logic              ack_drv_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o,
  output logic              stop_o
);

  localparam int CNT_W    = $clog2(BYTE_W + 2);
  localparam int ACK_SLOT = BYTE_W + 1;

  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic              ack_q, valid_q, stop_q;
  logic [BYTE_W-1:0] data_q;

  // Named internal events, used by logic and assertions alike
  logic active, bit_take, byte_done, slot_end, mc_seen, addr_ok;
  assign active    = (phase != PH_IDLE);
  assign bit_take  = active && scl_rise && (cnt < CNT_W'(BYTE_W));
  assign byte_done = active && scl_fall && (cnt == CNT_W'(BYTE_W));
  assign slot_end  = active && scl_fall && (cnt == CNT_W'(ACK_SLOT));
  assign mc_seen   = f_is_master_code(shreg);
  assign addr_ok   = f_addr_hit(shreg, own_addr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      ack_q   <= 1'b0;
      data_q  <= '0;
      valid_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      stop_q  <= 1'b0;
      if (start_evt) begin
        phase <= PH_ADDR;
        cnt   <= '0;
        ack_q <= 1'b0;
      end else if (stop_evt) begin
        phase  <= PH_IDLE;
        cnt    <= '0;
        ack_q  <= 1'b0;
        stop_q <= 1'b1;
      end else if (bit_take) begin
        shreg <= {shreg[BYTE_W-2:0], sda_s};
        cnt   <= cnt + 1'b1;
      end else if (byte_done) begin
        cnt <= CNT_W'(ACK_SLOT);
        if (phase == PH_ADDR) begin
          if (mc_seen) begin
            ack_q <= 1'b0;
          end else if (addr_ok) begin
            ack_q <= !ack_dis_i;
            phase <= PH_DATA;
          end else begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end
        end else begin
          ack_q   <= !ack_dis_i;
          data_q  <= shreg;
          valid_q <= 1'b1;
        end
      end else if (slot_end) begin
        ack_q <= 1'b0;
        cnt   <= '0;
      end
    end
  end

  assign ack_drv_o = ack_q;
  assign data_o    = data_q;
  assign valid_o   = valid_q;
  assign stop_o    = stop_q;

  AST_ACK_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (cnt == CNT_W'(ACK_SLOT))); // R5
  AST_ACK_HONOURS_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> !$past(ack_dis_i)); // R6
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R4
  AST_START_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (cnt == '0)); // R2
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!ack_q && phase == PH_IDLE)); // R2
  AST_NO_ACK_MASTER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_ADDR && mc_seen) |=> !ack_q); // R10
  AST_STOP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> !stop_q); // R7

endmodule

// File: rtl/twire_wr_slave.sv
module twire_wr_slave
  import twire_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              ack_dis_i,
  output logic              ack_n_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              stop_o
);

  logic [1:0] line_s;
  logic scl_rise, scl_fall, start_evt, stop_evt, ack_drv;

  twire_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({scl_i, sda_i}),
    .sync_o  (line_s)
  );

  twire_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (line_s[1]),
    .sda_s     (line_s[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  twire_byte_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .sda_s      (line_s[0]),
    .own_addr_i (own_addr_i),
    .ack_dis_i  (ack_dis_i),
    .ack_drv_o  (ack_drv),
    .data_o     (rx_data_o),
    .valid_o    (rx_valid_o),
    .stop_o     (stop_o)
  );

  assign ack_n_o = ~ack_drv;

  AST_VALID_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> (ack_n_o == $past(ack_dis_i))); // R4
  AST_NO_STROBE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise || scl_fall) |-> !(start_evt || stop_evt)); // R2

endmodule

// File: tb/twire_wr_slave_tb.sv
module twire_wr_slave_tb;

  localparam int Q = 8;  // system clocks per quarter SCL period
  localparam logic [6:0] MY_ADDR = 7'h3A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda = 1'b1;
  logic [6:0] own_addr = MY_ADDR;
  logic       ack_dis = 1'b0;
  logic       ack_n_o, rx_valid_o, stop_o;
  logic [7:0] rx_data_o;

  int n_chk = 0;
  int n_fail = 0;
  int stop_seen = 0;
  int stop_exp = 0;
  logic [7:0] exp_q [$];

  always #5 clk = ~clk;

  twire_wr_slave u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda),
    .own_addr_i (own_addr),
    .ack_dis_i  (ack_dis),
    .ack_n_o    (ack_n_o),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o),
    .stop_o     (stop_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Reference model: every clock, any strobe must match the queue head
  always @(negedge clk) begin
    if (rst_n && rx_valid_o) begin
      if (exp_q.size() == 0) check(1'b0, "R4/R9 unexpected strobe", rx_data_o, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(rx_data_o == e, "R3/R4 data byte", rx_data_o, e);
        check(ack_n_o == ack_dis, "R4 ack with strobe", ack_n_o, ack_dis);
      end
    end
    if (rst_n && stop_o) stop_seen++;
  end

  task automatic do_start();
    if (scl == 1'b0) begin
      sda = 1'b1; wait_clk(Q);
      scl = 1'b1; wait_clk(Q);
    end
    sda = 1'b0; wait_clk(2*Q);
    scl = 1'b0; wait_clk(Q);
  endtask

  task automatic do_stop();
    sda = 1'b0; wait_clk(Q);
    scl = 1'b1; wait_clk(2*Q);
    sda = 1'b1; wait_clk(2*Q);
    stop_exp++;
    check(stop_seen == stop_exp, "R7 stop strobe count", stop_seen, stop_exp);
  endtask

  task automatic send_bit(input logic b);
    sda = b;    wait_clk(Q);
    scl = 1'b1; wait_clk(2*Q);
    scl = 1'b0; wait_clk(Q);
  endtask

  // Eight bits MSB first, then the acknowledge slot with master released
  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda = 1'b1; wait_clk(Q);
    scl = 1'b1; wait_clk(Q);
    check(ack_n_o == !exp_ack, req, ack_n_o, !exp_ack);
    wait_clk(Q);
    scl = 1'b0; wait_clk(Q);
    check(ack_n_o == 1'b1, "R5 ack released after ninth clock", ack_n_o, 1);
  endtask

  initial begin
    wait_clk(5);
    check(ack_n_o == 1'b1, "R1 ack released in reset", ack_n_o, 1);
    rst_n = 1'b1;
    wait_clk(5);
    check(ack_n_o == 1'b1, "R1 ack idle after reset", ack_n_o, 1);
    check(rx_valid_o == 1'b0 && stop_o == 1'b0, "R1 strobes idle", rx_valid_o, 0);

    // R8/R4/R3: matching write, three data bytes
    do_start();
    send_byte({MY_ADDR, 1'b0}, 1'b1, "R8 matching write address ack");
    exp_q.push_back(8'hA5); send_byte(8'hA5, 1'b1, "R5 data ack");
    exp_q.push_back(8'h01); send_byte(8'h01, 1'b1, "R5 data ack");
    exp_q.push_back(8'h80); send_byte(8'h80, 1'b1, "R5 data ack");
    do_stop();
    check(exp_q.size() == 0, "R4 all bytes delivered", exp_q.size(), 0);

    // R9: read direction is refused and bus ignored
    do_start();
    send_byte({MY_ADDR, 1'b1}, 1'b0, "R9 read address no ack");
    send_byte(8'h5C, 1'b0, "R9 ignored byte no ack");
    do_stop();

    // R9: wrong address
    do_start();
    send_byte({MY_ADDR ^ 7'h01, 1'b0}, 1'b0, "R9 mismatch no ack");
    send_byte(8'hC3, 1'b0, "R9 ignored byte no ack");
    do_stop();

    // R6: acknowledge disabled, bytes still delivered
    ack_dis = 1'b1;
    do_start();
    send_byte({MY_ADDR, 1'b0}, 1'b0, "R6 address ack suppressed");
    exp_q.push_back(8'h3C); send_byte(8'h3C, 1'b0, "R6 data ack suppressed");
    do_stop();
    ack_dis = 1'b0;
    check(exp_q.size() == 0, "R6 byte delivered with ack off", exp_q.size(), 0);

    // R10: master code, then repeated start and normal service
    do_start();
    send_byte(8'b0000_1011, 1'b0, "R10 master code no ack");
    do_start();
    send_byte({MY_ADDR, 1'b0}, 1'b1, "R10 address after master code");
    exp_q.push_back(8'h96); send_byte(8'h96, 1'b1, "R10 data after master code");
    do_stop();

    // R2: repeated start in mid-byte discards partial data
    do_start();
    send_byte({MY_ADDR, 1'b0}, 1'b1, "R2 address ack");
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    do_start();
    send_byte({MY_ADDR, 1'b0}, 1'b1, "R2 address after mid-byte restart");
    exp_q.push_back(8'h7E); send_byte(8'h7E, 1'b1, "R2 data after restart");
    do_stop();

    // R1: stray clocks without START are ignored
    scl = 1'b0; wait_clk(Q);
    send_byte(8'hFF, 1'b0, "R1 no start no ack");
    scl = 1'b1; wait_clk(2*Q);

    wait_clk(10);
    check(exp_q.size() == 0, "R4 queue drained", exp_q.size(), 0);
    report();
  end

  initial begin
    wait_clk(150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    report();
  end

endmodule